// File: doc/BRIEF.md
# Interrupt presentation controller

This block sits in front of one processor and presents at most one interrupt to it at a time. It holds a current processor priority, a single pending slot (source number, priority and the source that delivered it), and a software inter-processor interrupt (IPI) priority. A source unit offers an interrupt through a delivery port and learns in the same cycle whether the offer was taken or bounced. When a more favoured offer or IPI lands on an occupied slot, the displaced interrupt is handed back to its source with a reject strobe, and the source is expected to offer it again later.

The processor drives single-cycle operations: accept (take the pending interrupt and raise its priority to the current level), end of interrupt, set current priority, and set IPI priority. The block forwards end-of-interrupt numbers to the source side and asks the source side to resend bounced work whenever the slot is left empty. A lower priority value is more favoured; 0xFF means nothing pending or fully masked.

Top module: `intr_present_ctl`

## Requirements
- R1: After reset the status word reads 0x00000000 (current priority 0x00, nothing pending), the IPI priority is 0xFF, the pending priority is 0xFF and `irq_out` is low.
- R2: `st_word` is the 32-bit status word, with the current priority in bits 31:24 and the pending source number in bits 23:0, where zero means empty. During an accept it shows the word as it stood before that accept. `irq_out` is high exactly when the pending number is nonzero.
- R3: In every cycle with `ofr_valid` high, exactly one of `ofr_take` and `ofr_rej` is high, combinationally and in that cycle. Without `ofr_valid`, neither is high.
- R4: An offer is bounced when its priority is not below the current priority, or when the slot is occupied by a pending priority less than or equal to the offered one. Otherwise it is taken.
- R5: A taken offer stores its number, priority and source index, and raises `irq_out` from the next cycle. If it displaces a pending entry that has an owner, a reject strobe carries the old number and owner in the same cycle.
- R6: Accept (op code 0) copies the pending priority into the current priority, empties the slot, sets the pending priority to 0xFF, forgets the owner and lowers `irq_out`.
- R7: End of interrupt (op code 1) loads bits 31:24 of `op_wdata` as the current priority. It strobes `eoi_valid` with bits 23:0. If the slot is empty, it strobes `resend_req` and runs the IPI re-check (R10).
- R8: Set IPI (op code 3) stores `op_wdata[7:0]`. If that value is below the current priority and the slot does not hold a pending priority less than or equal to it, any owned pending entry is rejected. The slot then takes source number 2 with that priority and no owner, and `irq_out` rises.
- R9: Set current priority (op code 2, value in `op_wdata[7:0]`) to a value below the old one that is also less than or equal to the pending priority empties the slot, sets the pending priority to 0xFF and lowers `irq_out`. The cleared entry is rejected to its owner only if it has one, so a displaced or masked IPI produces no reject strobe.
- R10: Set current priority to a value not below the old one, while the slot is empty, strobes `resend_req`. In that case, and on the empty-slot end of interrupt, the IPI is installed as in R8 when the IPI priority is below the new current priority.
- R11: An offer in the same cycle as a processor operation is bounced, and the operation alone decides the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ofr_valid | input | 1 | Offer strobe from the source side |
| ofr_num | input | 24 | Offered source number |
| ofr_prio | input | 8 | Offered priority |
| ofr_src | input | SRC_W | Index of the offering source unit |
| ofr_take | output | 1 | Offer taken (same cycle) |
| ofr_rej | output | 1 | Offer bounced (same cycle) |
| op_valid | input | 1 | Processor operation strobe |
| op_kind | input | 2 | 0 accept, 1 end of interrupt, 2 set current priority, 3 set IPI priority |
| op_wdata | input | 32 | Operation data word |
| st_word | output | 32 | Status word {current priority, pending number} |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Displaced-entry reject strobe |
| rej_num | output | 24 | Number of the rejected entry |
| rej_src | output | SRC_W | Owner of the rejected entry |
| eoi_valid | output | 1 | End-of-interrupt notification strobe |
| eoi_num | output | 24 | Number carried by the notification |
| resend_req | output | 1 | Request for the source side to resend |

## Verification
The assertions assume that offered source numbers are nonzero and never equal the IPI code 2, since the slot tracks occupancy through a nonzero number and the line-follows-slot property depends on it. They also assume strobes are sampled as single-cycle events. The stimulus builds every offer number by forcing a bit above the low byte, which keeps it clear of both zero and the IPI code. Operation data and priorities are otherwise unconstrained, including 0x00 and 0xFF, and offers collide freely with operations.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int PRIO_W = 8;
  localparam int NUM_W  = 24;
  localparam int WORD_W = PRIO_W + NUM_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef enum logic [1:0] {
    OP_ACCEPT  = 2'd0,
    OP_EOI     = 2'd1,
    OP_SET_CUR = 2'd2,
    OP_SET_IPI = 2'd3
  } op_kind_e;

  // a candidate wins the slot when it beats the current level and the occupant
  function automatic logic beats_slot(input logic [PRIO_W-1:0] cand,
                                      input logic [PRIO_W-1:0] cur,
                                      input logic occ,
                                      input logic [PRIO_W-1:0] pend);
    return (cand < cur) && !(occ && (pend <= cand));
  endfunction

  // tightening the current level hides the pending entry
  function automatic logic level_masks(input logic [PRIO_W-1:0] new_cur,
                                       input logic [PRIO_W-1:0] old_cur,
                                       input logic occ,
                                       input logic [PRIO_W-1:0] pend);
    return (new_cur < old_cur) && occ && (new_cur <= pend);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic [PRIO_W-1:0] cur,
                                                  input logic [NUM_W-1:0] num);
    return {cur, num};
  endfunction
endpackage

// File: rtl/ipc_offer_gate.sv
module ipc_offer_gate
  import ipc_pkg::*;
(
  input  logic              ofr_valid,
  input  logic [PRIO_W-1:0] ofr_prio,
  input  logic              op_busy,
  input  logic [PRIO_W-1:0] cur_q,
  input  logic              occ_q,
  input  logic [PRIO_W-1:0] pend_q,
  output logic              take,
  output logic              bounce
);
  always_comb begin
    take   = ofr_valid && !op_busy && beats_slot(ofr_prio, cur_q, occ_q, pend_q);
    bounce = ofr_valid && !take;
  end
endmodule

// File: rtl/ipc_op_unit.sv
module ipc_op_unit
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 2,
  parameter int IPI_NUM = 2
) (
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [WORD_W-1:0] op_wdata,
  input  logic [PRIO_W-1:0] cur_q,
  input  logic [PRIO_W-1:0] ipi_q,
  input  logic [PRIO_W-1:0] pend_q,
  input  logic [NUM_W-1:0]  num_q,
  input  logic              ownv_q,
  input  logic [SRC_W-1:0]  own_q,
  input  logic              irq_q,
  output logic [PRIO_W-1:0] cur_d,
  output logic [PRIO_W-1:0] ipi_d,
  output logic [PRIO_W-1:0] pend_d,
  output logic [NUM_W-1:0]  num_d,
  output logic              ownv_d,
  output logic [SRC_W-1:0]  own_d,
  output logic              irq_d,
  output logic              rej_v,
  output logic [NUM_W-1:0]  rej_n,
  output logic [SRC_W-1:0]  rej_s,
  output logic              eoi_v,
  output logic [NUM_W-1:0]  eoi_n,
  output logic              resend
);
  localparam logic [NUM_W-1:0] IPI_CODE = NUM_W'(IPI_NUM);

  logic              occ;
  logic [PRIO_W-1:0] lo_byte;
  logic [PRIO_W-1:0] hi_byte;
  op_kind_e          kind;

  assign occ     = (num_q != '0);
  assign lo_byte = op_wdata[PRIO_W-1:0];
  assign hi_byte = op_wdata[WORD_W-1 -: PRIO_W];
  assign kind    = op_kind_e'(op_kind);

  always_comb begin
    cur_d  = cur_q;
    ipi_d  = ipi_q;
    pend_d = pend_q;
    num_d  = num_q;
    ownv_d = ownv_q;
    own_d  = own_q;
    irq_d  = irq_q;
    rej_v  = 1'b0;
    rej_n  = num_q;
    rej_s  = own_q;
    eoi_v  = 1'b0;
    eoi_n  = op_wdata[NUM_W-1:0];
    resend = 1'b0;
    if (op_valid) begin
      unique case (kind)
        OP_ACCEPT: begin
          cur_d  = pend_q;
          num_d  = '0;
          pend_d = PRIO_NONE;
          ownv_d = 1'b0;
          irq_d  = 1'b0;
        end
        OP_EOI: begin
          cur_d = hi_byte;
          eoi_v = 1'b1;
          if (!occ) begin
            resend = 1'b1;
            if (ipi_q < hi_byte) begin
              num_d  = IPI_CODE;
              pend_d = ipi_q;
              ownv_d = 1'b0;
              irq_d  = 1'b1;
            end
          end
        end
        OP_SET_CUR: begin
          cur_d = lo_byte;
          if (lo_byte < cur_q) begin
            if (level_masks(lo_byte, cur_q, occ, pend_q)) begin
              num_d  = '0;
              pend_d = PRIO_NONE;
              ownv_d = 1'b0;
              irq_d  = 1'b0;
              rej_v  = ownv_q;
            end
          end else if (!occ) begin
            resend = 1'b1;
            if (ipi_q < lo_byte) begin
              num_d  = IPI_CODE;
              pend_d = ipi_q;
              ownv_d = 1'b0;
              irq_d  = 1'b1;
            end
          end
        end
        OP_SET_IPI: begin
          ipi_d = lo_byte;
          if (beats_slot(lo_byte, cur_q, occ, pend_q)) begin
            rej_v  = occ && ownv_q;
            num_d  = IPI_CODE;
            pend_d = lo_byte;
            ownv_d = 1'b0;
            irq_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intr_present_ctl.sv
module intr_present_ctl
  import ipc_pkg::*;
#(
  parameter int SRC_W   = 2,
  parameter int IPI_NUM = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ofr_valid,
  input  logic [NUM_W-1:0]  ofr_num,
  input  logic [PRIO_W-1:0] ofr_prio,
  input  logic [SRC_W-1:0]  ofr_src,
  output logic              ofr_take,
  output logic              ofr_rej,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [WORD_W-1:0] op_wdata,
  output logic [WORD_W-1:0] st_word,
  output logic              irq_out,
  output logic              rej_valid,
  output logic [NUM_W-1:0]  rej_num,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_valid,
  output logic [NUM_W-1:0]  eoi_num,
  output logic              resend_req
);
  logic [PRIO_W-1:0] cur_q, ipi_q, pend_q;
  logic [NUM_W-1:0]  num_q;
  logic              ownv_q, irq_q;
  logic [SRC_W-1:0]  own_q;

  logic [PRIO_W-1:0] op_cur, op_ipi, op_pend;
  logic [NUM_W-1:0]  op_num;
  logic              op_ownv, op_irq;
  logic [SRC_W-1:0]  op_own;
  logic              op_rej_v;
  logic [NUM_W-1:0]  op_rej_n;
  logic [SRC_W-1:0]  op_rej_s;

  logic [PRIO_W-1:0] cur_d, ipi_d, pend_d;
  logic [NUM_W-1:0]  num_d;
  logic              ownv_d, irq_d;
  logic [SRC_W-1:0]  own_d;

  // named events for the checker
  logic slot_occ;
  logic displace_evt;

  assign slot_occ     = (num_q != '0);
  assign displace_evt = ofr_take && slot_occ && ownv_q;

  ipc_offer_gate u_gate (
    .ofr_valid (ofr_valid),
    .ofr_prio  (ofr_prio),
    .op_busy   (op_valid),
    .cur_q     (cur_q),
    .occ_q     (slot_occ),
    .pend_q    (pend_q),
    .take      (ofr_take),
    .bounce    (ofr_rej)
  );

  ipc_op_unit #(.SRC_W(SRC_W), .IPI_NUM(IPI_NUM)) u_ops (
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_wdata (op_wdata),
    .cur_q    (cur_q),
    .ipi_q    (ipi_q),
    .pend_q   (pend_q),
    .num_q    (num_q),
    .ownv_q   (ownv_q),
    .own_q    (own_q),
    .irq_q    (irq_q),
    .cur_d    (op_cur),
    .ipi_d    (op_ipi),
    .pend_d   (op_pend),
    .num_d    (op_num),
    .ownv_d   (op_ownv),
    .own_d    (op_own),
    .irq_d    (op_irq),
    .rej_v    (op_rej_v),
    .rej_n    (op_rej_n),
    .rej_s    (op_rej_s),
    .eoi_v    (eoi_valid),
    .eoi_n    (eoi_num),
    .resend   (resend_req)
  );

  always_comb begin
    cur_d  = op_cur;
    ipi_d  = op_ipi;
    pend_d = op_pend;
    num_d  = op_num;
    ownv_d = op_ownv;
    own_d  = op_own;
    irq_d  = op_irq;
    if (ofr_take) begin
      num_d  = ofr_num;
      pend_d = ofr_prio;
      ownv_d = 1'b1;
      own_d  = ofr_src;
      irq_d  = 1'b1;
    end
  end

  // an offer is taken only without an op, so the two reject causes never meet
  assign rej_valid = op_rej_v || displace_evt;
  assign rej_num   = op_rej_v ? op_rej_n : num_q;
  assign rej_src   = op_rej_v ? op_rej_s : own_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      ipi_q  <= PRIO_NONE;
      pend_q <= PRIO_NONE;
      num_q  <= '0;
      ownv_q <= 1'b0;
      own_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      ipi_q  <= ipi_d;
      pend_q <= pend_d;
      num_q  <= num_d;
      ownv_q <= ownv_d;
      own_q  <= own_d;
      irq_q  <= irq_d;
    end
  end

  assign st_word = pack_word(cur_q, num_q);
  assign irq_out = irq_q;
endmodule

// File: rtl/ipc_chk.sv
module ipc_chk
  import ipc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ofr_valid,
  input logic [NUM_W-1:0]  ofr_num,
  input logic              ofr_take,
  input logic              ofr_rej,
  input logic              op_valid,
  input logic [1:0]        op_kind,
  input logic [WORD_W-1:0] op_wdata,
  input logic [WORD_W-1:0] st_word,
  input logic              irq_out,
  input logic              rej_valid,
  input logic              eoi_valid,
  input logic              displace_evt
);
  AST_OFFER_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    ofr_valid |-> (ofr_take != ofr_rej)); // R3
  AST_IDLE_NO_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    !ofr_valid |-> (!ofr_take && !ofr_rej)); // R3
  AST_OP_BOUNCES_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ofr_valid) |-> ofr_rej); // R11
  AST_TAKE_LOADS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ofr_take |=> (irq_out && (st_word[NUM_W-1:0] == $past(ofr_num)))); // R5
  AST_REJ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (op_valid || displace_evt)); // R5
  AST_ACCEPT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_ACCEPT) |=> (!irq_out && st_word[NUM_W-1:0] == '0)); // R6
  AST_EOI_LOADS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |=> (st_word[WORD_W-1 -: PRIO_W] == $past(op_wdata[WORD_W-1 -: PRIO_W]))); // R7
  AST_LINE_FOLLOWS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (st_word[NUM_W-1:0] != '0)); // R2
endmodule

bind intr_present_ctl ipc_chk u_ipc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ofr_valid    (ofr_valid),
  .ofr_num      (ofr_num),
  .ofr_take     (ofr_take),
  .ofr_rej      (ofr_rej),
  .op_valid     (op_valid),
  .op_kind      (op_kind),
  .op_wdata     (op_wdata),
  .st_word      (st_word),
  .irq_out      (irq_out),
  .rej_valid    (rej_valid),
  .eoi_valid    (eoi_valid),
  .displace_evt (displace_evt)
);

// File: tb/sim_intr_present_ctl.sv
module sim_intr_present_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ofr_valid = 1'b0;
  logic [23:0] ofr_num = '0;
  logic [7:0]  ofr_prio = '0;
  logic [1:0]  ofr_src = '0;
  logic        ofr_take, ofr_rej;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [31:0] op_wdata = '0;
  logic [31:0] st_word;
  logic        irq_out;
  logic        rej_valid;
  logic [23:0] rej_num;
  logic [1:0]  rej_src;
  logic        eoi_valid;
  logic [23:0] eoi_num;
  logic        resend_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench-side model of the slot
  logic [7:0]  m_cur, m_ipi, m_pend;
  logic [23:0] m_num;
  logic        m_ownv, m_irq;
  logic [1:0]  m_own;

  always #5 clk = ~clk;

  intr_present_ctl u0 (
    .clk(clk), .rst_n(rst_n),
    .ofr_valid(ofr_valid), .ofr_num(ofr_num), .ofr_prio(ofr_prio), .ofr_src(ofr_src),
    .ofr_take(ofr_take), .ofr_rej(ofr_rej),
    .op_valid(op_valid), .op_kind(op_kind), .op_wdata(op_wdata),
    .st_word(st_word), .irq_out(irq_out),
    .rej_valid(rej_valid), .rej_num(rej_num), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input string tag, input bit ov, input logic [23:0] on,
                     input logic [7:0] opr, input logic [1:0] os,
                     input bit pv, input logic [1:0] pk, input logic [31:0] pw);
    logic [7:0]  n_cur, n_ipi, n_pend, v;
    logic [23:0] n_num, e_rn, e_en;
    logic        n_ownv, n_irq, e_take, e_rej, e_rv, e_ev, e_rsq;
    logic [1:0]  n_own, e_rs;
    n_cur = m_cur; n_ipi = m_ipi; n_pend = m_pend; n_num = m_num;
    n_ownv = m_ownv; n_own = m_own; n_irq = m_irq;
    e_take = 0; e_rej = 0; e_rv = 0; e_rn = 0; e_rs = 0; e_ev = 0; e_en = 0; e_rsq = 0;
    v = pw[7:0];
    if (pv) begin
      if (ov) e_rej = 1;
      if (pk == 2'd0) begin
        n_cur = m_pend; n_num = 0; n_pend = 8'hFF; n_ownv = 0; n_irq = 0;
      end else if (pk == 2'd1) begin
        n_cur = pw[31:24]; e_ev = 1; e_en = pw[23:0];
        if (m_num == 0) begin
          e_rsq = 1;
          if (m_ipi < n_cur) begin n_num = 2; n_pend = m_ipi; n_ownv = 0; n_irq = 1; end
        end
      end else if (pk == 2'd2) begin
        n_cur = v;
        if (v < m_cur) begin
          if (m_num != 0 && v <= m_pend) begin
            n_num = 0; n_pend = 8'hFF; n_irq = 0; n_ownv = 0;
            if (m_ownv) begin e_rv = 1; e_rn = m_num; e_rs = m_own; end
          end
        end else if (m_num == 0) begin
          e_rsq = 1;
          if (m_ipi < v) begin n_num = 2; n_pend = m_ipi; n_ownv = 0; n_irq = 1; end
        end
      end else begin
        n_ipi = v;
        if (v < m_cur && !(m_num != 0 && m_pend <= v)) begin
          if (m_num != 0 && m_ownv) begin e_rv = 1; e_rn = m_num; e_rs = m_own; end
          n_num = 2; n_pend = v; n_ownv = 0; n_irq = 1;
        end
      end
    end else if (ov) begin
      if (opr < m_cur && !(m_num != 0 && m_pend <= opr)) begin
        e_take = 1;
        if (m_num != 0 && m_ownv) begin e_rv = 1; e_rn = m_num; e_rs = m_own; end
        n_num = on; n_pend = opr; n_ownv = 1; n_own = os; n_irq = 1;
      end else e_rej = 1;
    end
    ofr_valid = ov; ofr_num = on; ofr_prio = opr; ofr_src = os;
    op_valid = pv; op_kind = pk; op_wdata = pw;
    #1;
    chk(st_word == {m_cur, m_num}, "R2", "status word", st_word, {m_cur, m_num});
    if (ov) chk(ofr_take ^ ofr_rej, "R3", "single answer", {ofr_take, ofr_rej}, 32'h0);
    chk(ofr_take == e_take && ofr_rej == e_rej, tag, "take/bounce",
        {ofr_take, ofr_rej}, {e_take, e_rej});
    chk(rej_valid == e_rv && (!e_rv || (rej_num == e_rn && rej_src == e_rs)), tag,
        "reject strobe", {rej_valid, rej_src, rej_num}, {e_rv, e_rs, e_rn});
    chk(eoi_valid == e_ev && (!e_ev || eoi_num == e_en), tag, "eoi strobe",
        {eoi_valid, eoi_num}, {e_ev, e_en});
    chk(resend_req == e_rsq, tag, "resend", resend_req, e_rsq);
    @(posedge clk);
    m_cur = n_cur; m_ipi = n_ipi; m_pend = n_pend; m_num = n_num;
    m_ownv = n_ownv; m_own = n_own; m_irq = n_irq;
    @(negedge clk);
    ofr_valid = 0; op_valid = 0;
    chk(irq_out == m_irq, tag, "irq line", irq_out, m_irq);
  endtask

  initial begin
    logic [15:0] lf;
    m_cur = 8'h00; m_ipi = 8'hFF; m_pend = 8'hFF; m_num = 0; m_ownv = 0; m_own = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, and the 0xFF IPI level stays dormant on an empty end of interrupt
    chk(st_word == 32'h0, "R1", "reset word", st_word, 32'h0);
    chk(irq_out == 1'b0, "R1", "reset irq", irq_out, 32'h0);
    run("R1", 0, 0, 0, 0, 1, 2'd1, 32'hFF00_0000);
    run("R1", 0, 0, 0, 0, 1, 2'd2, 32'h0000_0000);
    // R11: collision with an op
    run("R11", 1, 24'h000105, 8'h05, 2'd1, 1, 2'd2, 32'h0000_0080);
    // R4: not below the current level
    run("R4", 1, 24'h000190, 8'h90, 2'd1, 0, 0, 0);
    run("R4", 1, 24'h000180, 8'h80, 2'd1, 0, 0, 0);
    // R5: take, equal-priority bounce, displacement
    run("R5", 1, 24'h000110, 8'h40, 2'd1, 0, 0, 0);
    run("R4", 1, 24'h000120, 8'h40, 2'd3, 0, 0, 0);
    run("R5", 1, 24'h000130, 8'h20, 2'd2, 0, 0, 0);
    // R6: accept
    run("R6", 0, 0, 0, 0, 1, 2'd0, 0);
    // R7: end of interrupt with empty slot
    run("R7", 0, 0, 0, 0, 1, 2'd1, 32'h8000_0130);
    // R8: IPI install
    run("R8", 0, 0, 0, 0, 1, 2'd3, 32'h0000_0010);
    // R9: offer displaces IPI silently, then tightened level masks the owned entry
    run("R9", 1, 24'h000144, 8'h05, 2'd3, 0, 0, 0);
    run("R9", 0, 0, 0, 0, 1, 2'd2, 32'h0000_0003);
    // R10: loosen level with empty slot
    run("R10", 0, 0, 0, 0, 1, 2'd2, 32'h0000_00F0);
    run("R9", 0, 0, 0, 0, 1, 2'd2, 32'h0000_0001);
    run("R10", 0, 0, 0, 0, 1, 2'd2, 32'h0000_0001);
    // R4 sweep: current level x occupant priority x offered priority
    for (int c = 0; c < 256; c += 51) begin
      for (int p = 0; p < 256; p += 37) begin
        for (int o = 0; o < 256; o += 23) begin
          run("R4", 0, 0, 0, 0, 1, 2'd0, 0);
          run("R4", 0, 0, 0, 0, 1, 2'd3, 32'h0000_00FF);
          run("R4", 0, 0, 0, 0, 1, 2'd2, 32'h0000_00FF);
          run("R4", 1, 24'h000200 | 24'(p), 8'(p), 2'(p), 0, 0, 0);
          run("R4", 0, 0, 0, 0, 1, 2'd2, 32'(c));
          run("R5", 1, 24'h000400 | 24'(o), 8'(o), 2'(o + 1), 0, 0, 0);
        end
      end
    end
    // mixed stream
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      w = {lf[7:0], 8'h00, lf[15:8]} ^ {lf, lf};
      run("R5", lf[0] | lf[1], 24'h000100 | 24'(lf[15:4]), lf[11:4], lf[3:2],
          lf[5] & lf[6], lf[8:7], w);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #5_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule